// File: doc/BRIEF.md
# Multi-port masked synchronous memory

This block is a parameterised word-addressed storage array with three groups of access ports. Read-only ports fetch words. Combined ports use a write-mode bit on each access to either read or write. Write-only ports store words. Word width, depth, address width, the number of ports in each group and the read latency are parameters. A mask granularity parameter splits each word into lanes, and each lane can be written on its own.

A read request passes through a configurable number of register stages on its address and enable. The array is then looked up combinationally, with no register after it. When no read arrives, a read port keeps showing the last word it returned. Writes update the array at the clock edge that samples them. When several ports write the same lane in one cycle, a fixed port order decides which one wins. All ports share one clock.

Top module: `mport_mem`

## Requirements
- R1: A write sampled at a clock edge updates the array at that edge, so any lookup active after that edge sees the new word. The write-latency parameter must be 1; any other value is rejected at elaboration.
- R2: The number of mask bits per port is WIDTH/MASK_GRAN. With MASK_GRAN = 0 the lane is the whole word, there is a single mask bit, the mask inputs are ignored, and an enabled write stores the full word.
- R3: Mask bit i of a port covers word bits [i*GRAN +: GRAN], so bit 0 covers the least-significant lane. Lanes whose mask bit is 0 keep their old contents.
- R4: A read whose address and enable are sampled at edge p passes through READ_LAT register stages. For READ_LAT >= 1 its word appears on the output after edge p+READ_LAT-1, and it reflects every write up to and including that edge. No register follows the array.
- R5: While a read channel's delayed enable is low, its output holds the last word it returned. Reset clears the delay stages and the held words to zero.
- R6: On a combined port, a read is requested when en=1 and wmode=0, and a write is requested when en=1 and wmode=1. A write-mode access does not change that port's read output.
- R7: When several ports write the same lane in one cycle, write-only ports outrank combined ports, and within a group the higher index wins. Priority is resolved lane by lane.
- R8: A lookup active in a cycle returns the array contents from before any write sampled at the edge that closes that cycle (read-before-write).
- R9: Port k of a group occupies bits [k*N +: N] of every vector of that group, where N is that vector's per-port width (ADDR_W, 1, WIDTH or WIDTH/GRAN).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all ports |
| rst_n | input | 1 | Asynchronous active-low reset of the read pipelines and held words |
| rd_addr | input | NUM_R*ADDR_W | Read-only port addresses |
| rd_en | input | NUM_R | Read-only port enables |
| rd_data | output | NUM_R*WIDTH | Read-only port data |
| rw_addr | input | NUM_RW*ADDR_W | Combined port addresses |
| rw_en | input | NUM_RW | Combined port enables |
| rw_wmode | input | NUM_RW | Combined port write-mode bits (1 = write) |
| rw_wdata | input | NUM_RW*WIDTH | Combined port write data |
| rw_wmask | input | NUM_RW*WIDTH/GRAN | Combined port lane masks |
| rw_rdata | output | NUM_RW*WIDTH | Combined port read data |
| wr_addr | input | NUM_W*ADDR_W | Write-only port addresses |
| wr_en | input | NUM_W | Write-only port enables |
| wr_data | input | NUM_W*WIDTH | Write-only port data |
| wr_mask | input | NUM_W*WIDTH/GRAN | Write-only port lane masks |

## Verification
The hardest case to bring about is four ports writing different lanes of one word in a single cycle. A lookup of that word must then land exactly in the window between the last delay stage and the next write. The directed stimulus places a read two edges ahead of a write to the same address, which exposes the old word and then the held word. A long random phase confines every address to four words, so overlapping writes, partial masks, write-mode accesses and idle holds occur often. Each read channel is scored against a lane-accurate model of the array on every cycle.

// File: rtl/mport_mem.sv
`timescale 1ns/1ps
module mport_mem #(
  parameter int WIDTH     = 16,
  parameter int DEPTH     = 16,
  parameter int ADDR_W    = 4,
  parameter int MASK_GRAN = 4,
  parameter int READ_LAT  = 2,
  parameter int WRITE_LAT = 1,
  parameter int NUM_R     = 2,
  parameter int NUM_RW    = 2,
  parameter int NUM_W     = 2,
  localparam int GRAN     = (MASK_GRAN == 0) ? WIDTH : MASK_GRAN,
  localparam int MBITS    = WIDTH / GRAN
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_R*ADDR_W-1:0]  rd_addr,
  input  logic [NUM_R-1:0]         rd_en,
  output logic [NUM_R*WIDTH-1:0]   rd_data,
  input  logic [NUM_RW*ADDR_W-1:0] rw_addr,
  input  logic [NUM_RW-1:0]        rw_en,
  input  logic [NUM_RW-1:0]        rw_wmode,
  input  logic [NUM_RW*WIDTH-1:0]  rw_wdata,
  input  logic [NUM_RW*MBITS-1:0]  rw_wmask,
  output logic [NUM_RW*WIDTH-1:0]  rw_rdata,
  input  logic [NUM_W*ADDR_W-1:0]  wr_addr,
  input  logic [NUM_W-1:0]         wr_en,
  input  logic [NUM_W*WIDTH-1:0]   wr_data,
  input  logic [NUM_W*MBITS-1:0]   wr_mask
);
  localparam int NRD = NUM_R + NUM_RW;
  localparam int NWR = NUM_RW + NUM_W;

  // R1: only single-cycle writes are legal
  if (WRITE_LAT != 1) begin : g_bad_wlat
    $error("mport_mem: write latency must be 1");
  end
  if (WIDTH % GRAN != 0) begin : g_bad_gran
    $error("mport_mem: mask granularity must divide the word width");
  end
  if (DEPTH > (1 << ADDR_W)) begin : g_bad_depth
    $error("mport_mem: depth exceeds the address range");
  end
  if (NUM_R < 1 || NUM_RW < 1 || NUM_W < 1) begin : g_bad_ports
    $error("mport_mem: each port group needs at least one port");
  end

  logic [WIDTH-1:0] mem [DEPTH];

  // read channels: read-only ports first, then combined ports (R6)
  logic [NRD*ADDR_W-1:0] ra_in, ra_q;
  logic [NRD-1:0]        re_in, re_q;
  logic [NRD*WIDTH-1:0]  rdv;

  assign ra_in = {rw_addr, rd_addr};
  assign re_in = {rw_en & ~rw_wmode, rd_en};

  if (READ_LAT == 0) begin : g_lat0
    assign ra_q = ra_in;
    assign re_q = re_in;
  end else begin : g_latn
    logic [NRD*ADDR_W-1:0] a_st [READ_LAT];
    logic [NRD-1:0]        e_st [READ_LAT];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < READ_LAT; s++) begin
          a_st[s] <= '0;
          e_st[s] <= '0;
        end
      end else begin
        a_st[0] <= ra_in;
        e_st[0] <= re_in;
        for (int s = 1; s < READ_LAT; s++) begin
          a_st[s] <= a_st[s-1];
          e_st[s] <= e_st[s-1];
        end
      end
    end
    assign ra_q = a_st[READ_LAT-1];
    assign re_q = e_st[READ_LAT-1];
  end

  for (genvar c = 0; c < NRD; c++) begin : g_rch
    logic [WIDTH-1:0] look, hold_q;
    assign look = mem[ra_q[c*ADDR_W +: ADDR_W]];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold_q <= '0;
      else if (re_q[c]) hold_q <= look;
    end
    assign rdv[c*WIDTH +: WIDTH] = re_q[c] ? look : hold_q;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !re_q[c] |-> $stable(rdv[c*WIDTH +: WIDTH]))
      else $error("read channel output moved without a read"); // R5
  end

  assign rd_data  = rdv[NUM_R*WIDTH-1:0];
  assign rw_rdata = rdv[NRD*WIDTH-1:NUM_R*WIDTH];

  // write channels: combined ports first, then write-only ports (R7)
  logic [NWR*ADDR_W-1:0] wa;
  logic [NWR-1:0]        we;
  logic [NWR*WIDTH-1:0]  wd, wbits;
  logic [NWR*MBITS-1:0]  wm;

  assign wa = {wr_addr, rw_addr};
  assign we = {wr_en, rw_en & rw_wmode};
  assign wd = {wr_data, rw_wdata};
  assign wm = {wr_mask, rw_wmask} | {(NWR*MBITS){MBITS == 1}};

  for (genvar c = 0; c < NWR; c++) begin : g_wch
    for (genvar l = 0; l < MBITS; l++) begin : g_lane
      assign wbits[c*WIDTH + l*GRAN +: GRAN] = {GRAN{wm[c*MBITS + l]}};
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NWR; c++)
      for (int l = 0; l < MBITS; l++)
        if (we[c] && wm[c*MBITS + l])
          mem[wa[c*ADDR_W +: ADDR_W]][l*GRAN +: GRAN] <= wd[c*WIDTH + l*GRAN +: GRAN];
  end

  AST_TOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[NUM_W-1] |=>
      ((mem[$past(wr_addr[(NUM_W-1)*ADDR_W +: ADDR_W])] & $past(wbits[(NWR-1)*WIDTH +: WIDTH]))
       == ($past(wr_data[(NUM_W-1)*WIDTH +: WIDTH]) & $past(wbits[(NWR-1)*WIDTH +: WIDTH]))))
    else $error("top priority write lost"); // R7

  AST_RW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_en[NUM_RW-1] && rw_wmode[NUM_RW-1] && !(|wr_en)) |=>
      ((mem[$past(rw_addr[(NUM_RW-1)*ADDR_W +: ADDR_W])] & $past(wbits[(NUM_RW-1)*WIDTH +: WIDTH]))
       == ($past(rw_wdata[(NUM_RW-1)*WIDTH +: WIDTH]) & $past(wbits[(NUM_RW-1)*WIDTH +: WIDTH]))))
    else $error("combined port write lost"); // R6

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data == '0 && rw_rdata == '0))
    else $error("read outputs not cleared by reset"); // R5
endmodule

// File: tb/mport_mem_tb.sv
`timescale 1ns/1ps
module mport_mem_tb;
  localparam int W = 16, D = 16, AW = 4, G = 4, MB = 4, L = 2;
  localparam int NR = 2, NRW = 2, NW = 2, NCH = NR + NRW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NR*AW-1:0]  rd_addr;  logic [NR-1:0]  rd_en;  logic [NR*W-1:0] rd_data;
  logic [NRW*AW-1:0] rw_addr;  logic [NRW-1:0] rw_en, rw_wmode;
  logic [NRW*W-1:0]  rw_wdata, rw_rdata;  logic [NRW*MB-1:0] rw_wmask;
  logic [NW*AW-1:0]  wr_addr;  logic [NW-1:0]  wr_en;
  logic [NW*W-1:0]   wr_data;  logic [NW*MB-1:0] wr_mask;

  logic [AW-1:0] f_raddr, f_rwaddr, f_waddr;
  logic f_ren, f_rwen, f_rwmode, f_wen, f_rwmask, f_wmask;
  logic [W-1:0] f_rdata, f_rwdata, f_rwrdata, f_wdata;

  mport_mem #(.WIDTH(W), .DEPTH(D), .ADDR_W(AW), .MASK_GRAN(G), .READ_LAT(L),
              .NUM_R(NR), .NUM_RW(NRW), .NUM_W(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data),
    .rw_addr(rw_addr), .rw_en(rw_en), .rw_wmode(rw_wmode), .rw_wdata(rw_wdata),
    .rw_wmask(rw_wmask), .rw_rdata(rw_rdata), .wr_addr(wr_addr), .wr_en(wr_en),
    .wr_data(wr_data), .wr_mask(wr_mask));

  mport_mem #(.WIDTH(W), .DEPTH(D), .ADDR_W(AW), .MASK_GRAN(0), .READ_LAT(L),
              .NUM_R(1), .NUM_RW(1), .NUM_W(1)) u_full (
    .clk(clk), .rst_n(rst_n), .rd_addr(f_raddr), .rd_en(f_ren), .rd_data(f_rdata),
    .rw_addr(f_rwaddr), .rw_en(f_rwen), .rw_wmode(f_rwmode), .rw_wdata(f_rwdata),
    .rw_wmask(f_rwmask), .rw_rdata(f_rwrdata), .wr_addr(f_waddr), .wr_en(f_wen),
    .wr_data(f_wdata), .wr_mask(f_wmask));

  typedef struct { int ch; int addr; int due; } item_t;
  item_t q[$];
  logic [W-1:0] refm [D];
  logic [W-1:0] last [NCH];
  logic [NCH*W-1:0] all_rd;
  assign all_rd = {rw_rdata, rd_data};
  int ec = 0, nchk = 0, nerr = 0;
  bit chk_on = 0, done = 0;
  string phase = "reset";

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [AW-1:0] a, input logic [W-1:0] d, input logic [MB-1:0] m);
    for (int l = 0; l < MB; l++) if (m[l]) refm[a][l*G +: G] = d[l*G +: G];
  endtask

  // driver side: issue reads into the scoreboard queue, update the model in priority order
  task automatic capture_issue();
    for (int p = 0; p < NR; p++)
      if (rd_en[p]) q.push_back('{p, int'(rd_addr[p*AW +: AW]), ec + L});
    for (int p = 0; p < NRW; p++)
      if (rw_en[p] && !rw_wmode[p]) q.push_back('{NR + p, int'(rw_addr[p*AW +: AW]), ec + L});
    for (int p = 0; p < NRW; p++)
      if (rw_en[p] && rw_wmode[p])
        apply(rw_addr[p*AW +: AW], rw_wdata[p*W +: W], rw_wmask[p*MB +: MB]);
    for (int p = 0; p < NW; p++)
      if (wr_en[p]) apply(wr_addr[p*AW +: AW], wr_data[p*W +: W], wr_mask[p*MB +: MB]);
  endtask

  always @(posedge clk) begin
    if (rst_n) capture_issue();
    ec++;
  end

  // monitor: pop due reads, compare every read channel each cycle
  always @(negedge clk) begin
    item_t it;
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) last[c] = '0;
      q.delete();
    end else begin
      while (q.size() > 0 && q[0].due <= ec) begin
        it = q.pop_front();
        last[it.ch] = refm[it.addr];
      end
      if (chk_on)
        for (int c = 0; c < NCH; c++)
          chk($sformatf("%s ch%0d", phase, c), all_rd[c*W +: W], last[c]);
    end
  end

  task automatic idle();
    rd_en = '0; rw_en = '0; rw_wmode = '0; wr_en = '0;
    f_ren = 0; f_rwen = 0; f_rwmode = 0; f_wen = 0;
  endtask
  task automatic step(); @(negedge clk); idle(); endtask
  task automatic rd(input int p, input int a);
    rd_en[p] = 1; rd_addr[p*AW +: AW] = AW'(a);
  endtask
  task automatic rw_rd(input int p, input int a);
    rw_en[p] = 1; rw_wmode[p] = 0; rw_addr[p*AW +: AW] = AW'(a);
  endtask
  task automatic rw_wr(input int p, input int a, input logic [W-1:0] d, input logic [MB-1:0] m);
    rw_en[p] = 1; rw_wmode[p] = 1; rw_addr[p*AW +: AW] = AW'(a);
    rw_wdata[p*W +: W] = d; rw_wmask[p*MB +: MB] = m;
  endtask
  task automatic wr(input int p, input int a, input logic [W-1:0] d, input logic [MB-1:0] m);
    wr_en[p] = 1; wr_addr[p*AW +: AW] = AW'(a); wr_data[p*W +: W] = d; wr_mask[p*MB +: MB] = m;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rd_addr = '0; rw_addr = '0; wr_addr = '0; rw_wdata = '0; wr_data = '0;
    rw_wmask = '0; wr_mask = '0;
    f_raddr = '0; f_rwaddr = '0; f_waddr = '0; f_rwdata = '0; f_wdata = '0;
    f_rwmask = 0; f_wmask = 0;
    idle();
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk("R5 reset rd_data", rd_data[W-1:0], '0);
    chk("R5 reset rw_rdata", rw_rdata[W-1:0], '0);
    chk("R5 reset whole-word copy", f_rdata, '0);
    chk_on = 1;

    phase = "R9 R1 init";
    for (int a = 0; a < D; a++) begin
      wr(a % 2, a, (16'h1111 * a[15:0]) ^ 16'h5A5A, 4'hF);
      step();
    end

    phase = "R4 R9 readback";
    for (int a = 0; a < D; a++) begin
      rd(0, a); rd(1, D - 1 - a); rw_rd(0, a); rw_rd(1, (a + 3) % D);
      step();
    end
    repeat (L + 1) step();

    phase = "R1 write then lookup";
    wr(0, 2, 16'hBEEF, 4'hF); rd(0, 2);
    step();
    rd(1, 2);
    step();
    chk("R1 R4 new word after one edge", rd_data[W-1:0], 16'hBEEF);
    repeat (L) step();

    phase = "R3 lanes";
    wr(1, 4, 16'hFFFF, 4'b0101);
    step(); rd(0, 4); step(); step();
    chk("R3 lanes 0 and 2 only", rd_data[W-1:0], 16'h1F1F);

    phase = "R7 priority";
    rw_wr(0, 6, 16'h1111, 4'hF); rw_wr(1, 6, 16'h2222, 4'h6);
    wr(0, 6, 16'h3333, 4'hC);    wr(1, 6, 16'h4444, 4'h8);
    step(); rd(0, 6); step(); step();
    chk("R7 lane-wise winner", rd_data[W-1:0], 16'h4321);

    phase = "R6 rw split";
    rw_wr(1, 7, 16'hC0DE, 4'hF);
    step(); rw_rd(1, 7); step(); step();
    chk("R6 combined port readback", rw_rdata[2*W-1:W], 16'hC0DE);

    phase = "R8 read before write";
    rd(0, 9);
    step(); step();
    chk("R8 old word in lookup cycle", rd_data[W-1:0], 16'hC3C3);
    wr(0, 9, 16'h7777, 4'hF);
    step();
    chk("R5 R8 held word after write", rd_data[W-1:0], 16'hC3C3);
    rd(0, 9); step(); step();
    chk("R8 new word on later read", rd_data[W-1:0], 16'h7777);

    phase = "R2 R3 R5 R6 R7 random";
    for (int n = 0; n < 3000; n++) begin
      rd_en = NR'($urandom); rw_en = NRW'($urandom); rw_wmode = NRW'($urandom);
      wr_en = NW'($urandom & $urandom);
      rw_wdata = NRW*W'({$urandom, $urandom}); wr_data = NW*W'({$urandom, $urandom});
      rw_wmask = NRW*MB'($urandom); wr_mask = NW*MB'($urandom);
      for (int p = 0; p < NR; p++)  rd_addr[p*AW +: AW] = AW'($urandom % 4);
      for (int p = 0; p < NRW; p++) rw_addr[p*AW +: AW] = AW'($urandom % 4);
      for (int p = 0; p < NW; p++)  wr_addr[p*AW +: AW] = AW'($urandom % 4);
      step();
    end
    repeat (L + 2) step();

    phase = "R2 whole word";
    f_wen = 1; f_waddr = 3; f_wdata = 16'hA5A5; f_wmask = 0;
    step(); f_ren = 1; f_raddr = 3; step(); step();
    chk("R2 mask ignored on write port", f_rdata, 16'hA5A5);
    f_rwen = 1; f_rwmode = 1; f_rwaddr = 3; f_rwdata = 16'h0F0F; f_rwmask = 0;
    step(); f_ren = 1; f_raddr = 3; step(); step();
    chk("R2 R6 mask ignored on combined port", f_rdata, 16'h0F0F);

    step();
    finish_run();
  end
endmodule